// File: doc/BRIEF.md
# Software/Hardware I2C Owner Arbiter

This block sits in front of a shared I2C master engine and decides who drives it. There are two candidates. The first is software, which works through one memory-mapped arbitration register. The second is an internal hardware agent, such as a link-protection engine, which uses a plain request/done handshake. Only one of them may own the engine and its pins at any time. The block gives each candidate its own grant line and steers the owner's command path onto the engine.

Software sets a request bit and then polls a read-only grant bit. If no grant arrives within its polling budget, software treats the bus as busy. The time from a request on an idle bus to the grant is therefore fixed, and the parameter `SETTLE_CYC` sets it. Software gives the engine back with a release strobe. Software can also force the hardware agent off the bus with an abort strobe. After an abort, the hardware agent is ignored until it drops its request line.

Ownership never changes in the middle of a transaction. The only exception is an abort. If both sides are waiting on an idle bus, hardware goes first.

Top module: `i2c_owner_arbiter`

## Requirements
- R1: After reset, neither grant is asserted, `arb_rdata` reads zero, `eng_sel` is 0 and `eng_cmd_valid` is low.
- R2: `arb_rdata` holds these bits, and all other bits read zero:
  - bit 0: software request pending.
  - bit 1: software grant.
  - bit 9: the hardware request line as sampled at the previous clock edge.
  - bit 17: hardware holds the grant.
- R3: A write with bit 0 set, made while the bus is idle and hardware is not requesting, raises `sw_grant` exactly `SETTLE_CYC`+1 clock edges after the write edge. It stays low before then.
- R4: A write with bit 8 set (release) clears the pending software request and drops `sw_grant` at the write edge. A waiting hardware request is then granted `SETTLE_CYC`+1 edges after the release edge.
- R5: When the bus is idle, `hw_grant` rises `SETTLE_CYC` edges after the first edge that samples `hw_req` high.
- R6: A `hw_done` pulse while hardware owns the bus drops `hw_grant` at that edge. A pending software request is then granted `SETTLE_CYC`+1 edges later.
- R7: While one side holds the grant, a request from the other side does not change either grant. The two grants are never high together.
- R8: When the bus is idle and both a software request and an unblocked hardware request are pending, hardware is granted first.
- R9: A write with bit 16 set (abort) while hardware owns the bus, or is being handed the bus, drops `hw_grant` at the write edge. `hw_req` is then ignored until it has been sampled low, and a pending software request is granted `SETTLE_CYC`+1 edges after the abort edge.
- R10: An abort write while software owns the bus changes neither the grants nor `arb_rdata`.
- R11: The engine command path works as follows:
  - `eng_sel` reads 1 while software owns the bus, 2 while hardware owns it, and 0 otherwise.
  - One edge after the owner presents a valid command, `eng_cmd_valid` and `eng_cmd` show it.
  - Commands from the side that does not own the bus never reach the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_wr | input | 1 | Write strobe for the arbitration register |
| arb_wdata | input | REG_W | Write data (bit 0 request, bit 8 release, bit 16 abort) |
| arb_rdata | output | REG_W | Arbitration register read value |
| hw_req | input | 1 | Hardware agent request line |
| hw_done | input | 1 | Hardware agent end-of-use pulse |
| hw_grant | output | 1 | Hardware agent owns the engine |
| sw_grant | output | 1 | Software owns the engine |
| sw_cmd_valid | input | 1 | Software command valid |
| sw_cmd | input | CMD_W | Software command/data word |
| hw_cmd_valid | input | 1 | Hardware command valid |
| hw_cmd | input | CMD_W | Hardware command/data word |
| eng_cmd_valid | output | 1 | Command valid toward the engine |
| eng_cmd | output | CMD_W | Command word toward the engine |
| eng_sel | output | 2 | Current owner: 0 none, 1 software, 2 hardware |

## Verification
The bench measures grant latency to the exact edge, both for software requests and for hardware requests. A design with an off-by-one settle counter would grant a cycle early or late and miss the polling window. The bench raises a hardware request while software owns the bus, and issues an abort while software owns it. A design that preempts would swap owners mid-transaction. A design that acts on any abort would disturb software. After an abort, the bench keeps the hardware request high across a software release. A design that forgets the block would hand the bus straight back to the aborted agent. A tie on an idle bus must go to hardware. The bench also drives commands from both sides at once, so that a leaking mux shows up as an unexpected engine word.

// File: rtl/i2c_arb_pkg.sv
`timescale 1ns/1ps
package i2c_arb_pkg;
  // Bit positions that software decodes in the arbitration register
  localparam int unsigned FLD_SW_ASK   = 0;
  localparam int unsigned FLD_SW_HAS   = 1;
  localparam int unsigned FLD_SW_DROP  = 8;
  localparam int unsigned FLD_HW_WANTS = 9;
  localparam int unsigned FLD_HW_KICK  = 16;
  localparam int unsigned FLD_HW_HAS   = 17;

  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_SETTLE = 2'd1,
    ARB_SW     = 2'd2,
    ARB_HW     = 2'd3
  } arb_state_e;

  typedef enum logic [1:0] {
    OWNER_NONE = 2'd0,
    OWNER_SW   = 2'd1,
    OWNER_HW   = 2'd2
  } owner_e;

  typedef struct packed {
    logic ask;
    logic drop;
    logic kick;
  } sw_strobe_t;
endpackage

// File: rtl/arb_regif.sv
`timescale 1ns/1ps
module arb_regif
  import i2c_arb_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             sw_has,
  input  logic             hw_has,
  input  logic             hw_req,
  output sw_strobe_t       stb,
  output logic             sw_pending,
  output logic [REG_W-1:0] rdata
);
  logic hw_need_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    stb.ask  = wr_en & wdata[FLD_SW_ASK];
    stb.drop = wr_en & wdata[FLD_SW_DROP];
    stb.kick = wr_en & wdata[FLD_HW_KICK];
  end

  // Release wins over a request carried by the same write
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_pending <= 1'b0;
      hw_need_q  <= 1'b0;
    end else begin
      hw_need_q <= hw_req;
      if (stb.drop)
        sw_pending <= 1'b0;
      else if (stb.ask)
        sw_pending <= 1'b1;
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[FLD_SW_ASK]   = sw_pending;
    rdata[FLD_SW_HAS]   = sw_has;
    rdata[FLD_HW_WANTS] = hw_need_q;
    rdata[FLD_HW_HAS]   = hw_has;
  end

  AST_RELEASE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (rst)
    stb.drop |=> !sw_pending); // R4
endmodule

// File: rtl/arb_fsm.sv
`timescale 1ns/1ps
module arb_fsm
  import i2c_arb_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_pending,
  input  logic drop,
  input  logic kick,
  input  logic hw_req,
  input  logic hw_done,
  output logic sw_grant,
  output logic hw_grant
);
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  arb_state_e       state, state_n;
  logic             tgt_hw, tgt_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             block, block_n;
  logic             hw_live;

  assign hw_live = hw_req & ~block;

  always_comb begin
    state_n = state;
    tgt_n   = tgt_hw;
    cnt_n   = cnt;
    block_n = block;
    if (!hw_req) block_n = 1'b0;
    unique case (state)
      ARB_IDLE: begin
        if (hw_live) begin
          state_n = ARB_SETTLE;
          tgt_n   = 1'b1;
          cnt_n   = '0;
        end else if (sw_pending && !drop) begin
          state_n = ARB_SETTLE;
          tgt_n   = 1'b0;
          cnt_n   = '0;
        end
      end
      ARB_SETTLE: begin
        if (tgt_hw && kick) begin
          state_n = ARB_IDLE;
          block_n = 1'b1;
        end else if (tgt_hw && !hw_req) begin
          state_n = ARB_IDLE;
        end else if (!tgt_hw && drop) begin
          state_n = ARB_IDLE;
        end else if (cnt == CNT_LAST) begin
          state_n = tgt_hw ? ARB_HW : ARB_SW;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ARB_SW: begin
        if (drop) state_n = ARB_IDLE;
      end
      ARB_HW: begin
        if (kick) begin
          state_n = ARB_IDLE;
          block_n = 1'b1;
        end else if (hw_done) begin
          state_n = ARB_IDLE;
        end
      end
      default: state_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ARB_IDLE;
      tgt_hw   <= 1'b0;
      cnt      <= '0;
      block    <= 1'b0;
      sw_grant <= 1'b0;
      hw_grant <= 1'b0;
    end else begin
      state    <= state_n;
      tgt_hw   <= tgt_n;
      cnt      <= cnt_n;
      block    <= block_n;
      sw_grant <= (state_n == ARB_SW);
      hw_grant <= (state_n == ARB_HW);
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(sw_grant && hw_grant)); // R7
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sw_grant && !drop) |=> sw_grant); // R7
  AST_HW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hw_grant && !kick && !hw_done) |=> hw_grant); // R7
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (sw_grant && drop) |=> !sw_grant); // R4
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (hw_grant && kick) |=> !hw_grant); // R9
  AST_BLOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    block |-> !hw_grant); // R9
  AST_TIE_TO_HW: assert property (@(posedge clk) disable iff (rst)
    (state == ARB_IDLE && hw_live && sw_pending) |=> (state == ARB_SETTLE && tgt_hw)); // R8
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ARB_SETTLE) |-> (32'(cnt) < SETTLE_CYC)); // R3
endmodule

// File: rtl/arb_cmd_mux.sv
`timescale 1ns/1ps
module arb_cmd_mux
  import i2c_arb_pkg::*;
#(
  parameter int unsigned CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_grant,
  input  logic             hw_grant,
  input  logic             sw_valid,
  input  logic [CMD_W-1:0] sw_cmd,
  input  logic             hw_valid,
  input  logic [CMD_W-1:0] hw_cmd,
  output logic             eng_valid,
  output logic [CMD_W-1:0] eng_cmd,
  output logic [1:0]       eng_sel
);
  logic take_sw, take_hw;

  assign take_sw = sw_grant & sw_valid;
  assign take_hw = hw_grant & hw_valid;

  always_comb begin
    if (hw_grant)      eng_sel = OWNER_HW;
    else if (sw_grant) eng_sel = OWNER_SW;
    else               eng_sel = OWNER_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_valid <= 1'b0;
      eng_cmd   <= '0;
    end else begin
      eng_valid <= take_sw | take_hw;
      if (take_hw)      eng_cmd <= hw_cmd;
      else if (take_sw) eng_cmd <= sw_cmd;
    end
  end

  AST_NO_OWNER_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!sw_grant && !hw_grant) |=> !eng_valid); // R11
  AST_SW_PATH: assert property (@(posedge clk) disable iff (rst)
    (sw_grant && sw_valid) |=> (eng_valid && eng_cmd == $past(sw_cmd))); // R11
  AST_HW_PATH: assert property (@(posedge clk) disable iff (rst)
    (hw_grant && hw_valid) |=> (eng_valid && eng_cmd == $past(hw_cmd))); // R11
endmodule

// File: rtl/i2c_owner_arbiter.sv
`timescale 1ns/1ps
module i2c_owner_arbiter
  import i2c_arb_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_wr,
  input  logic [REG_W-1:0] arb_wdata,
  output logic [REG_W-1:0] arb_rdata,
  input  logic             hw_req,
  input  logic             hw_done,
  output logic             hw_grant,
  output logic             sw_grant,
  input  logic             sw_cmd_valid,
  input  logic [CMD_W-1:0] sw_cmd,
  input  logic             hw_cmd_valid,
  input  logic [CMD_W-1:0] hw_cmd,
  output logic             eng_cmd_valid,
  output logic [CMD_W-1:0] eng_cmd,
  output logic [1:0]       eng_sel
);
  sw_strobe_t stb;
  logic       sw_pending;

  arb_regif #(.REG_W(REG_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (arb_wr),
    .wdata      (arb_wdata),
    .sw_has     (sw_grant),
    .hw_has     (hw_grant),
    .hw_req     (hw_req),
    .stb        (stb),
    .sw_pending (sw_pending),
    .rdata      (arb_rdata)
  );

  arb_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sw_pending (sw_pending),
    .drop       (stb.drop),
    .kick       (stb.kick),
    .hw_req     (hw_req),
    .hw_done    (hw_done),
    .sw_grant   (sw_grant),
    .hw_grant   (hw_grant)
  );

  arb_cmd_mux #(.CMD_W(CMD_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .sw_grant  (sw_grant),
    .hw_grant  (hw_grant),
    .sw_valid  (sw_cmd_valid),
    .sw_cmd    (sw_cmd),
    .hw_valid  (hw_cmd_valid),
    .hw_cmd    (hw_cmd),
    .eng_valid (eng_cmd_valid),
    .eng_cmd   (eng_cmd),
    .eng_sel   (eng_sel)
  );

  AST_ABORT_IGNORED_FOR_SW: assert property (@(posedge clk) disable iff (rst)
    (sw_grant && stb.kick && !stb.drop) |=> sw_grant); // R10
endmodule

// File: tb/sim_i2c_owner_arbiter.sv
`timescale 1ns/1ps
module sim_i2c_owner_arbiter;
  localparam int unsigned REG_W = 32;
  localparam int unsigned CMD_W = 16;
  localparam int unsigned S     = 4;
  localparam time         CLK_P = 8ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             arb_wr = 1'b0;
  logic [REG_W-1:0] arb_wdata = '0;
  logic [REG_W-1:0] arb_rdata;
  logic             hw_req = 1'b0, hw_done = 1'b0;
  logic             hw_grant, sw_grant;
  logic             sw_cmd_valid = 1'b0, hw_cmd_valid = 1'b0;
  logic [CMD_W-1:0] sw_cmd = '0, hw_cmd = '0;
  logic             eng_cmd_valid;
  logic [CMD_W-1:0] eng_cmd;
  logic [1:0]       eng_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [CMD_W-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c_owner_arbiter #(.REG_W(REG_W), .CMD_W(CMD_W), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst(rst), .arb_wr(arb_wr), .arb_wdata(arb_wdata), .arb_rdata(arb_rdata),
    .hw_req(hw_req), .hw_done(hw_done), .hw_grant(hw_grant), .sw_grant(sw_grant),
    .sw_cmd_valid(sw_cmd_valid), .sw_cmd(sw_cmd), .hw_cmd_valid(hw_cmd_valid), .hw_cmd(hw_cmd),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_sel(eng_sel)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [REG_W-1:0] d);
    arb_wr    = 1'b1;
    arb_wdata = d;
    tick();
    arb_wr    = 1'b0;
    arb_wdata = '0;
  endtask

  // Driver: presents both command ports for one edge, queues what the owner sent
  task automatic send_cmds(input logic sv, input logic [CMD_W-1:0] sc,
                           input logic hv, input logic [CMD_W-1:0] hc);
    sw_cmd_valid = sv; sw_cmd = sc;
    hw_cmd_valid = hv; hw_cmd = hc;
    if (hw_grant && hv)      exp_q.push_back(hc);
    else if (sw_grant && sv) exp_q.push_back(sc);
    tick();
    sw_cmd_valid = 1'b0;
    hw_cmd_valid = 1'b0;
  endtask

  // Monitor: every engine word must match the head of the queue
  always @(negedge clk) begin
    if (!rst && eng_cmd_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: got engine word %h expected none", eng_cmd);
      end else begin
        logic [CMD_W-1:0] e;
        e = exp_q.pop_front();
        if (eng_cmd !== e) begin
          n_bad++;
          $display("FAIL R11: got engine word %h expected %h", eng_cmd, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 sw_grant", 32'(sw_grant), 0);
    chk("R1 hw_grant", 32'(hw_grant), 0);
    chk("R1 rdata", arb_rdata, 0);
    chk("R1 eng_sel", 32'(eng_sel), 0);
    chk("R1 eng_valid", 32'(eng_cmd_valid), 0);

    // R3 software request latency, R2 readback
    reg_write(32'h1);
    chk("R2 pending bit0", arb_rdata, 32'h1);
    tick(S);
    chk("R3 grant not early", 32'(sw_grant), 0);
    tick();
    chk("R3 grant on time", 32'(sw_grant), 1);
    chk("R2 granted read", arb_rdata, 32'h3);
    chk("R11 sel sw", 32'(eng_sel), 1);

    // R11 owner path passes, non-owner ignored
    send_cmds(1'b1, 16'hA5A5, 1'b1, 16'h1234);
    send_cmds(1'b0, 16'h0000, 1'b1, 16'h5678);
    tick();

    // R7 hardware request does not preempt software
    hw_req = 1'b1;
    tick(S + 3);
    chk("R7 hw waits", 32'(hw_grant), 0);
    chk("R7 sw keeps", 32'(sw_grant), 1);
    chk("R2 hw need bit9", arb_rdata, 32'h203);

    // R10 abort with software owner has no effect
    reg_write(32'h1_0000);
    chk("R10 sw keeps", 32'(sw_grant), 1);
    chk("R10 rdata same", arb_rdata, 32'h203);

    // R4 release hands over to waiting hardware
    reg_write(32'h100);
    chk("R4 sw dropped", 32'(sw_grant), 0);
    chk("R4 rdata", arb_rdata, 32'h200);
    tick(S);
    chk("R4 hw not early", 32'(hw_grant), 0);
    tick();
    chk("R4 hw granted", 32'(hw_grant), 1);
    chk("R2 hw using bit17", arb_rdata, 32'h2_0200);
    chk("R11 sel hw", 32'(eng_sel), 2);
    send_cmds(1'b1, 16'h1111, 1'b1, 16'hBEEF);
    tick();

    // R6 hardware done hands over to pending software
    reg_write(32'h1);
    tick(2);
    chk("R7 sw waits", 32'(sw_grant), 0);
    hw_done = 1'b1; hw_req = 1'b0;
    tick();
    hw_done = 1'b0;
    chk("R6 hw dropped", 32'(hw_grant), 0);
    tick(S);
    chk("R6 sw not early", 32'(sw_grant), 0);
    tick();
    chk("R6 sw granted", 32'(sw_grant), 1);

    // R8 tie on idle bus goes to hardware
    reg_write(32'h100);
    tick(2);
    arb_wr = 1'b1; arb_wdata = 32'h1;
    tick();
    arb_wr = 1'b0; arb_wdata = '0;
    hw_req = 1'b1;
    tick();
    tick(S - 1);
    chk("R8 none yet", 32'({hw_grant, sw_grant}), 0);
    tick();
    chk("R8 hw first", 32'(hw_grant), 1);
    chk("R8 sw waits", 32'(sw_grant), 0);
    chk("R5 rdata", arb_rdata, 32'h2_0201);

    // R9 abort while hardware owns, software pending
    reg_write(32'h1_0000);
    chk("R9 hw dropped", 32'(hw_grant), 0);
    tick(S);
    chk("R9 sw not early", 32'(sw_grant), 0);
    tick();
    chk("R9 sw granted", 32'(sw_grant), 1);
    chk("R9 rdata", arb_rdata, 32'h203);
    reg_write(32'h100);
    tick(S + 3);
    chk("R9 blocked while req high", 32'(hw_grant), 0);
    hw_req = 1'b0;
    tick();
    // R5 fresh hardware request on idle bus
    hw_req = 1'b1;
    tick(S);
    chk("R5 hw not early", 32'(hw_grant), 0);
    tick();
    chk("R5 hw granted", 32'(hw_grant), 1);
    hw_done = 1'b1; hw_req = 1'b0;
    tick();
    hw_done = 1'b0;
    tick(2);

    chk("R11 queue drained", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule